// File: doc/BRIEF.md
# RS485 Half-Duplex Line Direction Controller

This block steers the driver-enable of an RS485 transceiver for a UART that shares one pair of wires in both directions. The direction output is active low. When the controller is switched on and a character is waiting, or the shifter is busy, it turns the line driver on. It then tells the serializer, through a permit output, that the start bit may go out. When the transmit queue and the shift register are both empty, meaning the final stop bit has left the wire, it counts a programmable number of bit periods. After that count it releases the driver so that the far station can answer.

When the function is switched off, the direction pin simply follows a level supplied by software. The permit output stays high, so the serializer is never held back. The block also supplies the source signal for the transmit-empty interrupt:
- with direction control on, that signal means "shift register drained";
- with direction control off, it means "queue empty".

The delay is taken from a 4-bit field and counted in whole bit periods, marked by a one-cycle tick from the baud generator. New traffic during the countdown cancels it and keeps the driver on.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset, with dir_en=1, fifo_empty=1 and tx_busy=0, drv_n is 1 and tx_ok is 0.
- R2: With dir_en=0, drv_n equals sw_drv_n and tx_ok is 1 in the same cycle, whatever bit_tick, tx_busy and fifo_empty do.
- R3: With dir_en=1 and the controller idle, fifo_empty=0 or tx_busy=1 drives drv_n to 0 and tx_ok to 1 at the next rising clock edge. With dir_en=1, tx_ok is never 1 while drv_n is 1.
- R4: With dir_en=1, drv_n stays 0 in every cycle that follows a cycle with tx_busy=1 or fifo_empty=0.
- R5: With a delay D of 1 to 15, the line becomes quiet when tx_busy=0 and fifo_empty=1 are first seen together. drv_n then returns to 1 at the clock edge that samples the D-th bit_tick after that point. Earlier ticks leave it at 0.
- R6: With D=0, drv_n returns to 1 at the clock edge that first samples the quiet line.
- R7: If tx_busy=1 or fifo_empty=0 appears during the countdown, drv_n stays 0. The next quiet period counts the full delay again.
- R8: txe_src is fifo_empty AND NOT tx_busy while dir_en=1, and equals fifo_empty while dir_en=0.
- R9: turn_dly is captured when the countdown begins. Changing it during the countdown does not change when drv_n is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_en | input | 1 | Enables automatic direction control |
| sw_drv_n | input | 1 | Software level for the direction pin while disabled |
| turn_dly | input | 4 | Turnaround delay in bit periods (0 to 15) |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_busy | input | 1 | Shift register holds a character (includes the stop bit) |
| fifo_empty | input | 1 | Transmit queue is empty |
| drv_n | output | 1 | Transceiver driver enable, active low |
| tx_ok | output | 1 | Serializer may begin a start bit |
| txe_src | output | 1 | Source of the transmit-empty interrupt |

## Verification
The assertions assume the following:
- tx_busy stays high through the whole stop bit.
- bit_tick is a single-cycle pulse.
- The serializer begins a character only while tx_ok is high.

The random stimulus follows these rules. It sets tx_busy from low to high only when the bench's own expected tx_ok is high. It drops the tick onto single cycles. It holds dir_en and turn_dly steady for most cycles while still switching them now and then, including during a countdown.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_TURN  = 2'd2
  } dir_state_t;
endpackage

// File: rtl/rs485_turn_cnt.sv
module rs485_turn_cnt #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [DLY_W-1:0] load_val,
  output logic             last
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (dec && remain_q != '0) begin
      remain_q <= remain_q - ONE;
    end
  end

  assign last = (remain_q == ONE);
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_en,
  input  logic       line_quiet,
  input  logic       bit_tick,
  input  logic       dly_zero,
  input  logic       cnt_last,
  output dir_state_t state,
  output logic       cnt_load,
  output logic       cnt_dec
);
  dir_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (!dir_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!line_quiet) state_d = ST_DRIVE;
        end
        ST_DRIVE: begin
          if (line_quiet) begin
            if (dly_zero) begin
              state_d = ST_IDLE;
            end else begin
              state_d  = ST_TURN;
              cnt_load = 1'b1;
            end
          end
        end
        ST_TURN: begin
          if (!line_quiet) begin
            state_d = ST_DRIVE;
          end else if (bit_tick) begin
            if (cnt_last) state_d = ST_IDLE;
            else cnt_dec = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/rs485_txe_sel.sv
module rs485_txe_sel (
  input  logic dir_en,
  input  logic fifo_empty,
  input  logic line_quiet,
  output logic txe_src
);
  always_comb begin
    if (dir_en) txe_src = line_quiet;
    else txe_src = fifo_empty;
  end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_en,
  input  logic             sw_drv_n,
  input  logic [DLY_W-1:0] turn_dly,
  input  logic             bit_tick,
  input  logic             tx_busy,
  input  logic             fifo_empty,
  output logic             drv_n,
  output logic             tx_ok,
  output logic             txe_src
);
  logic       line_quiet;
  logic       dly_zero;
  logic       cnt_load;
  logic       cnt_dec;
  logic       cnt_last;
  dir_state_t state;

  assign line_quiet = fifo_empty && !tx_busy;
  assign dly_zero   = (turn_dly == '0);

  rs485_dir_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_en     (dir_en),
    .line_quiet (line_quiet),
    .bit_tick   (bit_tick),
    .dly_zero   (dly_zero),
    .cnt_last   (cnt_last),
    .state      (state),
    .cnt_load   (cnt_load),
    .cnt_dec    (cnt_dec)
  );

  rs485_turn_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .dec      (cnt_dec),
    .load_val (turn_dly),
    .last     (cnt_last)
  );

  rs485_txe_sel u_txe (
    .dir_en     (dir_en),
    .fifo_empty (fifo_empty),
    .line_quiet (line_quiet),
    .txe_src    (txe_src)
  );

  assign drv_n = dir_en ? (state == ST_IDLE) : sw_drv_n;
  assign tx_ok = !dir_en || (state != ST_IDLE);
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk #(
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_en,
  input logic             sw_drv_n,
  input logic [DLY_W-1:0] turn_dly,
  input logic             bit_tick,
  input logic             tx_busy,
  input logic             fifo_empty,
  input logic             drv_n,
  input logic             tx_ok,
  input logic             txe_src
);
  AST_SW_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_en |-> (drv_n == sw_drv_n) && tx_ok); // R2

  AST_PERMIT_NEEDS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en && tx_ok |-> !drv_n); // R3

  AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en && (tx_busy || !fifo_empty) |=> !dir_en || !drv_n); // R4

  AST_RELEASE_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_n) && dir_en && $past(dir_en) |-> $past(fifo_empty && !tx_busy)); // R7

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_n) && dir_en && $past(dir_en) && ($past(turn_dly) != '0)
      |-> $past(bit_tick)); // R5

  AST_TXE_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en && tx_busy |-> !txe_src); // R8
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dir_en     (dir_en),
  .sw_drv_n   (sw_drv_n),
  .turn_dly   (turn_dly),
  .bit_tick   (bit_tick),
  .tx_busy    (tx_busy),
  .fifo_empty (fifo_empty),
  .drv_n      (drv_n),
  .tx_ok      (tx_ok),
  .txe_src    (txe_src)
);

// File: tb/rs485_dir_ctrl_tb.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_en = 1'b1;
  logic       sw_drv_n = 1'b1;
  logic [3:0] turn_dly = 4'd0;
  logic       bit_tick = 1'b0;
  logic       tx_busy = 1'b0;
  logic       fifo_empty = 1'b1;
  logic       drv_n, tx_ok, txe_src;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rs485_dir_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dir_en(dir_en), .sw_drv_n(sw_drv_n),
    .turn_dly(turn_dly), .bit_tick(bit_tick), .tx_busy(tx_busy),
    .fifo_empty(fifo_empty), .drv_n(drv_n), .tx_ok(tx_ok), .txe_src(txe_src)
  );

  // Behavioural model built from the requirements: 0 idle, 1 driving, 2 counting
  int m_st = 0;
  int m_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0;
    end else if (!dir_en) begin
      m_st = 0;
    end else begin
      case (m_st)
        0: if (tx_busy || !fifo_empty) m_st = 1;
        1: if (!tx_busy && fifo_empty) begin
             if (turn_dly == 0) m_st = 0;
             else begin m_st = 2; m_cnt = turn_dly; end
           end
        default: if (tx_busy || !fifo_empty) m_st = 1;
                 else if (bit_tick) begin
                   m_cnt = m_cnt - 1;
                   if (m_cnt == 0) m_st = 0;
                 end
      endcase
    end
  end

  function automatic bit exp_drv_n();
    return dir_en ? (m_st == 0) : sw_drv_n;
  endfunction
  function automatic bit exp_tx_ok();
    return !dir_en || (m_st != 0);
  endfunction
  function automatic bit exp_txe();
    return dir_en ? (fifo_empty && !tx_busy) : fifo_empty;
  endfunction

  task automatic chk(input bit got, input bit exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    step();
    bit_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(drv_n, 1'b1, "R1 drv_n");
    chk(tx_ok, 1'b0, "R1 tx_ok");

    // R2 disabled: follow software level, activity ignored
    dir_en = 1'b0; sw_drv_n = 1'b0; #1;
    chk(drv_n, 1'b0, "R2 drv_n sw0");
    chk(tx_ok, 1'b1, "R2 tx_ok");
    tx_busy = 1'b1; fifo_empty = 1'b0; bit_tick = 1'b1; step();
    sw_drv_n = 1'b1; #1;
    chk(drv_n, 1'b1, "R2 drv_n sw1");
    chk(txe_src, 1'b0, "R8 disabled fifo nonempty");
    fifo_empty = 1'b1; #1;
    chk(txe_src, 1'b1, "R8 disabled follows fifo_empty");
    tx_busy = 1'b0; bit_tick = 1'b0; step();

    // R3 start of transmission
    dir_en = 1'b1; turn_dly = 4'd3; step();
    chk(drv_n, 1'b1, "R3 idle before data");
    fifo_empty = 1'b0; #1;
    chk(drv_n, 1'b1, "R3 not before edge");
    step();
    chk(drv_n, 1'b0, "R3 drv_n asserted");
    chk(tx_ok, 1'b1, "R3 tx_ok granted");
    // R4 hold while busy
    fifo_empty = 1'b1; tx_busy = 1'b1; tick(); tick();
    chk(drv_n, 1'b0, "R4 held while busy");
    chk(txe_src, 1'b0, "R8 busy shifter");
    // R5 delay of 3 ticks, R9 field change ignored
    tx_busy = 1'b0; #1;
    chk(txe_src, 1'b1, "R8 shifter drained");
    step();
    turn_dly = 4'd0;
    tick(); chk(drv_n, 1'b0, "R5 after tick 1");
    step(); chk(drv_n, 1'b0, "R5 no tick no release");
    tick(); chk(drv_n, 1'b0, "R9 after tick 2");
    tick(); chk(drv_n, 1'b1, "R5 released after tick 3");

    // R6 zero delay
    tx_busy = 1'b1; step();
    chk(drv_n, 1'b0, "R6 driving");
    tx_busy = 1'b0; step();
    chk(drv_n, 1'b1, "R6 immediate release");

    // R7 cancel and restart countdown
    turn_dly = 4'd2; fifo_empty = 1'b0; step();
    fifo_empty = 1'b1; step();
    tick(); chk(drv_n, 1'b0, "R7 mid countdown");
    fifo_empty = 1'b0; step();
    chk(drv_n, 1'b0, "R7 cancelled");
    fifo_empty = 1'b1; step();
    tick(); chk(drv_n, 1'b0, "R7 full delay recounted");
    tick(); chk(drv_n, 1'b1, "R7 released after restart");

    // Random phase against the behavioural model
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 64) == 0) dir_en = ~dir_en;
      if (($urandom % 32) == 0) turn_dly = 4'($urandom % 6);
      sw_drv_n = 1'($urandom);
      bit_tick = (($urandom % 4) == 0);
      fifo_empty = (($urandom % 5) != 0);
      if (tx_busy) tx_busy = (($urandom % 4) != 0);
      else if (exp_tx_ok()) tx_busy = (($urandom % 6) == 0);
      #1;
      chk(txe_src, exp_txe(), "R8 random");
      chk(drv_n, exp_drv_n(), "R2 R4 R5 random pin");
      step();
      chk(drv_n, exp_drv_n(), "R3 R5 R7 random after edge");
      chk(tx_ok, exp_tx_ok(), "R3 random permit");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule